// File: doc/BRIEF.md
# Shared-Tap Periodic Rate Generator

This block turns a 32.768 kHz time-base, delivered as a one-cycle strobe on the system clock, into two periodic outputs. It has a 15-stage binary ripple-equivalent counter, built as a synchronous counter that advances only on time-base strobes. A 4-bit rate code picks one counter bit. That one choice sets both the square-wave frequency and the periodic-interrupt rate, so the two always move together. Each output has its own enable.

The square wave is the chosen counter bit, gated by its enable. The periodic flag sets each time the chosen bit goes from 0 to 1, whether or not the interrupt is enabled. A status read clears the flag. The active-low interrupt request is asserted while the flag and the interrupt enable are both set. Configuration is a plain register write: one strobe loads the rate code and both enables together.

Rate codes map to counter bits as follows:
- Code 0 selects nothing.
- Code 1 selects bit 6 (256 Hz).
- Code 2 selects bit 7 (128 Hz).
- Codes 3 to 15 select bit (code − 2). This runs from 8192 Hz for code 3 down to 2 Hz for code 15.

Only bits 1 to 13 of the 15 can ever be chosen.

Top module: `rg_rate_gen`

## Requirements
- R1: During and after reset the counter is zero, the rate code and both enables are cleared, stat_pf is 0, sqw_out is 0 and irq_n is 1.
- R2: The counter advances by one on each clock edge where tb_tick is 1 and holds on every other edge; with no ticks no output changes.
- R3: Rate code 1 selects counter bit 6, code 2 selects bit 7 and codes 3 to 15 select bit (code − 2); sqw_out equals the selected bit whenever the square wave is enabled.
- R4: Rate code 0 keeps sqw_out at 0 and never sets the periodic flag.
- R5: With the square-wave enable at 0, sqw_out is 0. The counter and the selected bit keep running, so re-enabling shows the same phase as if the output had never been disabled.
- R6: The periodic flag sets on the clock edge where the selected counter bit goes from 0 to 1, regardless of the interrupt enable.
- R7: A stat_rd strobe clears the flag on the next edge. If the flag sets on that same edge, the set wins.
- R8: irq_n is 0 exactly when the flag and the interrupt enable are both 1.
- R9: A change of rate code never sets the flag by itself; only a real 0-to-1 transition of the newly selected bit does.
- R10: With a tick on every clock, the square-wave period is 4 clocks at code 3 (122 µs in real time) and 16384 clocks at code 15 (500 ms).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | One-cycle strobe per 32.768 kHz time-base period |
| cfg_wr | input | 1 | Loads cfg_rate, cfg_sqw_en and cfg_pie |
| cfg_rate | input | 4 | Rate code to load |
| cfg_sqw_en | input | 1 | Square-wave enable to load |
| cfg_pie | input | 1 | Periodic-interrupt enable to load |
| stat_rd | input | 1 | Status read strobe; clears the flag |
| stat_pf | output | 1 | Periodic flag |
| sqw_out | output | 1 | Square-wave output |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default parameters: 15 counter stages and a 4-bit rate code. It often drives the time-base strobe on every clock, so that even the slowest tap, a 16384-clock period at code 15, fits within the run, and the full 15-bit wrap is reached. Random ticking, reads and rate changes test the flag against a bench model. Directed runs cover code 0, reads that coincide with a set, and disabled outputs.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int RATE_W    = 4;
  localparam int FAST_CODE = 3;   // first code of the halving run
  localparam int SLOW_TAP1 = 6;   // bit used by code 1
  localparam int SLOW_TAP2 = 7;   // bit used by code 2

  // counter bit chosen by a rate code (code 0 yields 0, unused)
  function automatic int tap_of(input logic [RATE_W-1:0] code);
    int r;
    case (code)
      '0:      r = 0;
      1:       r = SLOW_TAP1;
      2:       r = SLOW_TAP2;
      default: r = int'(code) - (FAST_CODE - 1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rg_divider.sv
module rg_divider #(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [STAGES-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R2: counter holds without a strobe and steps by one with it
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rg_tap_sel.sv
module rg_tap_sel
  import rg_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              tick,
  input  logic [STAGES-1:0] cnt,
  input  logic [RATE_W-1:0] rate,
  output logic              tap_lvl,
  output logic              pf_set
);
  localparam int IDX_W = $clog2(STAGES);

  logic [IDX_W-1:0]  idx;
  logic              tap_ok;
  logic [STAGES-1:0] low_ones;

  assign idx    = IDX_W'(tap_of(rate));
  assign tap_ok = (rate != '0);

  // every bit below the tap must be 1 for the tap to rise on this tick
  for (genvar i = 0; i < STAGES; i++) begin : g_low
    assign low_ones[i] = (idx <= IDX_W'(i)) | cnt[i];
  end

  assign tap_lvl = tap_ok & cnt[idx];
  assign pf_set  = tick & tap_ok & ~cnt[idx] & (&low_ones);

  // R4: code 0 never produces a rising tap
  always_comb begin
    p_code0_quiet_r4: assert (tap_ok || !(tap_lvl || pf_set));
  end
endmodule

// File: rtl/rg_flag.sv
module rg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic pie,
  output logic pf,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pf <= 1'b0;
    else if (set) pf <= 1'b1;
    else if (clr) pf <= 1'b0;
  end

  assign irq_n = ~(pf & pie);

  // R7: set beats a simultaneous read; a lone read clears
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pf);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pf);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(pf));
endmodule

// File: rtl/rg_rate_gen.sv
module rg_rate_gen
  import rg_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_tick,
  input  logic              cfg_wr,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_sqw_en,
  input  logic              cfg_pie,
  input  logic              stat_rd,
  output logic              stat_pf,
  output logic              sqw_out,
  output logic              irq_n
);
  logic [RATE_W-1:0] rate_q;
  logic              sqwe_q, pie_q;
  logic [STAGES-1:0] cnt;
  logic              tap_lvl, pf_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      sqwe_q <= 1'b0;
      pie_q  <= 1'b0;
    end else if (cfg_wr) begin
      rate_q <= cfg_rate;
      sqwe_q <= cfg_sqw_en;
      pie_q  <= cfg_pie;
    end
  end

  rg_divider #(.STAGES(STAGES)) div_i (
    .clk(clk), .rst_n(rst_n), .tick(tb_tick), .cnt(cnt)
  );

  rg_tap_sel #(.STAGES(STAGES)) sel_i (
    .tick(tb_tick), .cnt(cnt), .rate(rate_q),
    .tap_lvl(tap_lvl), .pf_set(pf_set)
  );

  rg_flag flag_i (
    .clk(clk), .rst_n(rst_n), .set(pf_set), .clr(stat_rd),
    .pie(pie_q), .pf(stat_pf), .irq_n(irq_n)
  );

  assign sqw_out = sqwe_q & tap_lvl;

  p_sqw_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sqwe_q |-> !sqw_out);
  p_code0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0) |-> (!pf_set && !sqw_out));
  // R6: a flag set marks the tap going high on the same edge
  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_set && !cfg_wr) |=> tap_lvl);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pie_q |-> irq_n);
endmodule

// File: tb/rg_rate_gen_tb_top.sv
module rg_rate_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_tick = 1'b0, cfg_wr = 1'b0, cfg_sqw_en = 1'b0, cfg_pie = 1'b0;
  logic stat_rd = 1'b0;
  logic [3:0] cfg_rate = '0;
  logic stat_pf, sqw_out, irq_n;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [14:0] m_cnt = '0;
  logic [3:0]  m_rate = '0;
  bit m_pf = 0, m_sqwe = 0, m_pie = 0;

  always #10 clk = ~clk;  // 50 MHz

  rg_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .cfg_wr(cfg_wr),
    .cfg_rate(cfg_rate), .cfg_sqw_en(cfg_sqw_en), .cfg_pie(cfg_pie),
    .stat_rd(stat_rd), .stat_pf(stat_pf), .sqw_out(sqw_out), .irq_n(irq_n)
  );

  function automatic int exp_bit(input logic [3:0] code);
    if (code == 4'd1) return 6;
    if (code == 4'd2) return 7;
    return int'(code) - 2;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: apply inputs, advance model, compare at the falling edge
  task automatic cyc(input bit tk, input bit rd, input bit wr,
                     input logic [3:0] r, input bit se, input bit pe,
                     input string tag);
    bit set;
    int b;
    logic [14:0] mask;
    tb_tick = tk; stat_rd = rd; cfg_wr = wr;
    cfg_rate = r; cfg_sqw_en = se; cfg_pie = pe;
    b = exp_bit(m_rate);
    mask = (15'(1) << b) - 15'(1);
    set = (m_rate != 0) && tk && !m_cnt[b] && ((m_cnt & mask) == mask);
    if (set) m_pf = 1;
    else if (rd) m_pf = 0;
    if (wr) begin m_rate = r; m_sqwe = se; m_pie = pe; end
    if (tk) m_cnt = m_cnt + 15'(1);
    @(posedge clk);
    @(negedge clk);
    b = exp_bit(m_rate);
    check({tag, " R3/R5 sqw_out"}, sqw_out, m_sqwe && (m_rate != 0) && m_cnt[b]);
    check({tag, " R6/R7/R9 stat_pf"}, stat_pf, m_pf);
    check({tag, " R8 irq_n"}, irq_n, !(m_pf && m_pie));
  endtask

  task automatic cfg(input logic [3:0] r, input bit se, input bit pe, input string tag);
    cyc(1'b1, 1'b0, 1'b1, r, se, pe, tag);
  endtask

  // full-rate period of sqw_out between two rising edges
  task automatic period(input logic [3:0] r, input int exp, input string tag);
    int n = 0, start = -1, got = -1;
    logic prev;
    cfg(r, 1'b1, 1'b0, tag);
    prev = sqw_out;
    while (got < 0 && n < 40000) begin
      cyc(1'b1, 1'b0, 1'b0, r, 1'b1, 1'b0, tag);
      n++;
      if (sqw_out && !prev) begin
        if (start < 0) start = n;
        else got = n - start;
      end
      prev = sqw_out;
    end
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s period: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 sqw_out in reset", sqw_out, 1'b0);
    check("R1 stat_pf in reset", stat_pf, 1'b0);
    check("R1 irq_n in reset", irq_n, 1'b1);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, "R1 after reset");

    // R4: code 0 with both enables on
    cfg(4'd0, 1'b1, 1'b1, "R4");
    repeat (200) cyc(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, "R4 code0");

    // R6/R5: flag sets with square wave off and interrupt off
    cfg(4'd3, 1'b0, 1'b0, "R6");
    repeat (30) cyc(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, "R6 pie off");
    cfg(4'd3, 1'b1, 1'b1, "R8");
    repeat (30) cyc(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, "R8 pie on");
    // R7: read every clock, sets coincide with reads
    repeat (40) cyc(1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, "R7 read storm");
    // R2: no ticks, nothing moves
    repeat (60) cyc(1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, "R2 no tick");
    // R3: slow codes
    cfg(4'd1, 1'b1, 1'b1, "R3");
    repeat (600) cyc(1'b1, ($urandom % 16) == 0, 1'b0, 4'd0, 1'b0, 1'b0, "R3 code1");
    cfg(4'd2, 1'b1, 1'b0, "R3");
    repeat (600) cyc(1'b1, ($urandom % 16) == 0, 1'b0, 4'd0, 1'b0, 1'b0, "R3 code2");

    // random phase: ticks, reads, rate changes (R9)
    for (int i = 0; i < 8000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 48) == 0,
          4'($urandom), 1'($urandom), 1'($urandom), "R9 random");
    end

    // R10: fastest and slowest period
    period(4'd3, 4, "R10 code3");
    period(4'd15, 16384, "R10 code15");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule